// File: doc/BRIEF.md
# Memory-to-Port Byte Mover with Request Sensing

This block is one DMA channel that shifts bytes between a memory region and a single, unchanging I/O port. Each byte costs two bus machine cycles. The first cycle reads the byte from the source into an internal holding register. The second cycle writes it to the destination. After each byte the memory pointer moves by one, up or down, and the port address stays the same. A 16-bit count decides how many bytes are moved. When the last byte has been written, the channel turns itself off and raises a completion flag.

Software programs the channel through a small register port. A peripheral paces the transfer through a request input, which can be read in one of two ways. In level sense, the request is looked at during the write cycle of each byte to decide whether the next byte follows at once. In edge sense, every new rising edge on the request buys exactly one byte.

The bus master port has a ready input, so a slow memory or peripheral can stretch either machine cycle.

Top module: `dma_mio_chan`

## Requirements
- R1: Register map, selected by `reg_addr`. Address 0 is the memory pointer (20 bits). Address 1 is the port address (16 bits). Address 2 is the byte count (16 bits). Address 3 is control: bit0 enable, bits 2:1 mode, bit3 edge sense (1) or level sense (0), and bit4 done, which is read-only. `reg_rdata` shows the selected register zero-extended. After reset every register and every field reads 0, `done` is 0 and `bus_req` is 0.
- R2: Mode 00 and mode 01 move bytes from memory to the port. The read cycle has `bus_io`=0 at the memory pointer and the write cycle has `bus_io`=1 at the port address. Mode 00 steps the pointer by +1 after each byte and mode 01 steps it by -1. The port address never changes.
- R3: Mode 10 and mode 11 move bytes from the port to memory. The read cycle has `bus_io`=1 at the port address and the write cycle has `bus_io`=0 at the memory pointer. Mode 10 steps the pointer by +1 and mode 11 steps it by -1.
- R4: Each byte is one read cycle (`bus_we`=0) followed directly by one write cycle (`bus_we`=1). The write cycle carries the byte captured in the read cycle, unchanged.
- R5: The count drops by one after each written byte. The write that brings it to zero clears enable and sets done. A write to the control register clears done.
- R6: In level sense, an enabled idle channel starts a byte while the request is high. Whether another byte follows is decided by the request level in the cycle in which the write cycle completes. If it is high, the next read starts with no idle cycle between.
- R7: In edge sense, each rising edge of the request starts exactly one byte, however long the request stays high. An edge that arrives while a byte is in flight is remembered and served afterwards.
- R8: The memory pointer wraps modulo 2^20 in both directions.
- R9: A register write made while the channel is enabled or a byte is in flight is ignored. The one exception is a control write with bit0 = 0.
- R10: A control write with bit0 = 0 made during a byte clears enable at once. The byte in flight still completes its write cycle, and no further byte starts.
- R11: While `bus_ready` is low the current machine cycle is held, with `bus_req`, `bus_we`, `bus_io` and `bus_addr` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Selected register, zero-extended |
| dreq | input | 1 | Peripheral transfer request |
| done | output | 1 | Transfer count exhausted |
| bus_req | output | 1 | Bus machine cycle active |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_io | output | 1 | 1 = I/O space, 0 = memory space |
| bus_addr | output | 20 | Cycle address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |
| bus_ready | input | 1 | Cycle completes on a clock edge where this is high |

## Verification
The bench targets the level-sense sampling point. It drops the request during a read and raises it during the following write, then does the reverse. A design that sampled in the read cycle, or at any time, would transfer the wrong number of bytes.

It holds an edge-sensed request high to catch a design that treats it as a level. It also pulses the request mid-byte to catch a design that loses an edge arriving during a transfer. Pointer runs that start next to 0 and next to 0xFFFFF expose a pointer that saturates or sign-extends instead of wrapping.

It issues a stop in the middle of a byte, which would expose a design that abandons the write cycle or keeps on moving bytes. It writes registers while the channel is armed, which would expose a design that lets those writes land.

// File: rtl/dma_mio_pkg.sv
package dma_mio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_state_e;

  localparam logic [2:0] RA_MADDR  = 3'd0;
  localparam logic [2:0] RA_IOADDR = 3'd1;
  localparam logic [2:0] RA_COUNT  = 3'd2;
  localparam logic [2:0] RA_CTRL   = 3'd3;
endpackage

// File: rtl/dma_mio_regs.sv
module dma_mio_regs
  import dma_mio_pkg::*;
#(
  parameter int MAW = 20,
  parameter int IOW = 16,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [2:0]     addr,
  input  logic [MAW-1:0] wdata,
  output logic [MAW-1:0] rdata,
  input  logic           seq_busy,
  input  logic           byte_done,
  output logic           en,
  output logic [1:0]     mode,
  output logic           edge_sel,
  output logic           done,
  output logic [MAW-1:0] maddr,
  output logic [IOW-1:0] ioaddr,
  output logic           last
);
  logic [MAW-1:0] maddr_q, maddr_d;
  logic [IOW-1:0] ioaddr_q, ioaddr_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           en_q, en_d, edge_q, edge_d, done_q, done_d;
  logic [1:0]     mode_q, mode_d;
  logic           accept, stop, ce;

  // writes land only when disarmed and idle; a control write with bit0 = 0 always stops
  assign accept = wr && !en_q && !seq_busy;
  assign stop   = wr && en_q && (addr == RA_CTRL) && !wdata[0];
  assign ce     = accept || stop || byte_done;

  always_comb begin
    maddr_d  = maddr_q;
    ioaddr_d = ioaddr_q;
    cnt_d    = cnt_q;
    en_d     = en_q;
    mode_d   = mode_q;
    edge_d   = edge_q;
    done_d   = done_q;
    if (accept) begin
      case (addr)
        RA_MADDR:  maddr_d  = wdata;
        RA_IOADDR: ioaddr_d = wdata[IOW-1:0];
        RA_COUNT:  cnt_d    = wdata[CW-1:0];
        RA_CTRL: begin
          en_d   = wdata[0];
          mode_d = wdata[2:1];
          edge_d = wdata[3];
          done_d = 1'b0;
        end
        default: ;
      endcase
    end else if (stop) begin
      en_d = 1'b0;
    end
    if (byte_done) begin
      maddr_d = mode_q[0] ? (maddr_q - MAW'(1)) : (maddr_q + MAW'(1));
      cnt_d   = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        en_d   = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maddr_q  <= '0;
      ioaddr_q <= '0;
      cnt_q    <= '0;
      en_q     <= 1'b0;
      mode_q   <= 2'b00;
      edge_q   <= 1'b0;
      done_q   <= 1'b0;
    end else if (ce) begin
      maddr_q  <= maddr_d;
      ioaddr_q <= ioaddr_d;
      cnt_q    <= cnt_d;
      en_q     <= en_d;
      mode_q   <= mode_d;
      edge_q   <= edge_d;
      done_q   <= done_d;
    end
  end

  always_comb begin
    case (addr)
      RA_MADDR:  rdata = maddr_q;
      RA_IOADDR: rdata = MAW'(ioaddr_q);
      RA_COUNT:  rdata = MAW'(cnt_q);
      RA_CTRL:   rdata = MAW'({done_q, edge_q, mode_q, en_q});
      default:   rdata = '0;
    endcase
  end

  assign en       = en_q;
  assign mode     = mode_q;
  assign edge_sel = edge_q;
  assign done     = done_q;
  assign maddr    = maddr_q;
  assign ioaddr   = ioaddr_q;
  assign last     = (cnt_q == CW'(1));

  // R5: completion always leaves the channel disarmed
  a_r5_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !en_q);
  // R9: configuration frozen while armed
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> ($stable(mode_q) && $stable(ioaddr_q) && $stable(edge_q)));
endmodule

// File: rtl/dma_mio_reqsense.sv
module dma_mio_reqsense (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic en,
  input  logic edge_sel,
  input  logic xfer_start,
  output logic go,
  output logic cont
);
  logic req_q, flag_q, flag_d, rise;

  assign rise = dreq && !req_q;

  always_comb begin
    flag_d = flag_q;
    if (xfer_start) flag_d = 1'b0;
    if (en && edge_sel && rise) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q  <= dreq;
      flag_q <= flag_d;
    end
  end

  assign go   = en && (edge_sel ? flag_q : dreq);
  assign cont = en && !edge_sel && dreq;

  // R7: a started byte consumes the pending edge unless a fresh one arrives
  a_r7_edge_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && edge_sel && !rise) |=> !flag_q);
endmodule

// File: rtl/dma_mio_seq.sv
module dma_mio_seq
  import dma_mio_pkg::*;
#(
  parameter int MAW = 20,
  parameter int IOW = 16,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           cont,
  input  logic           last,
  input  logic           to_mem,
  input  logic [MAW-1:0] maddr,
  input  logic [IOW-1:0] ioaddr,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           bus_ready,
  output logic           bus_req,
  output logic           bus_we,
  output logic           bus_io,
  output logic [MAW-1:0] bus_addr,
  output logic [DW-1:0]  bus_wdata,
  output logic           busy,
  output logic           xfer_start,
  output logic           byte_done
);
  seq_state_e state_q, state_d;
  logic [DW-1:0] data_q;
  logic          cap;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go) state_d = ST_RD;
      ST_RD:   if (bus_ready) state_d = ST_WR;
      ST_WR:   if (bus_ready) state_d = (cont && !last) ? ST_RD : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign cap = (state_q == ST_RD) && bus_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data_q <= '0;
    else if (cap) data_q <= bus_rdata;
  end

  assign xfer_start = (state_q == ST_IDLE) && go;
  assign byte_done  = (state_q == ST_WR) && bus_ready;
  assign busy       = (state_q != ST_IDLE);
  assign bus_req    = busy;
  assign bus_we     = (state_q == ST_WR);
  assign bus_io     = (state_q == ST_RD) ? to_mem : !to_mem;
  assign bus_addr   = bus_io ? MAW'(ioaddr) : maddr;
  assign bus_wdata  = data_q;

  // R4: a completed read is followed directly by a write
  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_ready) |=> (bus_req && bus_we));
  // R11: a stalled cycle keeps its attributes
  a_r11_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) && $stable(bus_io) && $stable(bus_addr)));
  // R6: nothing starts without a request
  a_r6_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> !bus_req);
endmodule

// File: rtl/dma_mio_chan.sv
module dma_mio_chan
  import dma_mio_pkg::*;
#(
  parameter int MAW = 20,
  parameter int IOW = 16,
  parameter int CW  = 16,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [2:0]     reg_addr,
  input  logic [MAW-1:0] reg_wdata,
  output logic [MAW-1:0] reg_rdata,
  input  logic           dreq,
  output logic           done,
  output logic           bus_req,
  output logic           bus_we,
  output logic           bus_io,
  output logic [MAW-1:0] bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           bus_ready
);
  logic [1:0]     rst_sync_q;
  logic           rst_i_n;
  logic           en, edge_sel, last, go, cont, busy, xfer_start, byte_done;
  logic [1:0]     mode;
  logic [MAW-1:0] maddr;
  logic [IOW-1:0] ioaddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  dma_mio_regs #(.MAW(MAW), .IOW(IOW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .seq_busy(busy), .byte_done(byte_done), .en(en), .mode(mode),
    .edge_sel(edge_sel), .done(done), .maddr(maddr), .ioaddr(ioaddr), .last(last)
  );

  dma_mio_reqsense u_req (
    .clk(clk), .rst_n(rst_i_n), .dreq(dreq), .en(en), .edge_sel(edge_sel),
    .xfer_start(xfer_start), .go(go), .cont(cont)
  );

  dma_mio_seq #(.MAW(MAW), .IOW(IOW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .go(go), .cont(cont), .last(last), .to_mem(mode[1]),
    .maddr(maddr), .ioaddr(ioaddr), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_io(bus_io), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .xfer_start(xfer_start), .byte_done(byte_done)
  );

  // R2/R3: direction of each machine cycle matches the mode
  a_r2_r3_direction: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_req |-> (bus_io == (bus_we ^ mode[1])));
endmodule

// File: tb/sim_dma_mio_chan.sv
module sim_dma_mio_chan;
  localparam logic [15:0] IOA = 16'hBEEF;
  // {waits, pad, mode[1:0], base[19:0], count[15:0]}
  localparam logic [39:0] VEC [8] = '{
    {1'b0, 1'b0, 2'b00, 20'h12340, 16'd5},
    {1'b0, 1'b0, 2'b01, 20'h00A10, 16'd4},
    {1'b0, 1'b0, 2'b10, 20'h55555, 16'd6},
    {1'b0, 1'b0, 2'b11, 20'h7FF03, 16'd3},
    {1'b0, 1'b0, 2'b00, 20'hFFFFE, 16'd4},
    {1'b0, 1'b0, 2'b11, 20'h00001, 16'd3},
    {1'b1, 1'b0, 2'b10, 20'h00100, 16'd3},
    {1'b1, 1'b0, 2'b01, 20'h20000, 16'd2}
  };

  logic        clk, rst_n, reg_wr, dreq, done, bus_req, bus_we, bus_io, bus_ready;
  logic [2:0]  reg_addr;
  logic [19:0] reg_wdata, reg_rdata, bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;

  int nchk = 0, nfail = 0, byte_idx = 0, busy_cyc = 0;
  logic [1:0]  cur_m;
  logic [19:0] cur_base;
  logic        wait_mode;
  logic        finished = 1'b0;

  dma_mio_chan u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dreq(dreq), .done(done), .bus_req(bus_req), .bus_we(bus_we),
    .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // memory returns a function of its address, the port returns a function of the byte index
  assign bus_rdata = bus_io ? (8'(byte_idx) ^ 8'h3C) : (bus_addr[7:0] ^ 8'hA5);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_ma(input int i);
    return cur_m[0] ? (cur_base - 20'(i)) : (cur_base + 20'(i));
  endfunction

  always @(negedge clk) begin
    bus_ready = wait_mode ? ~bus_ready : 1'b1;
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && bus_req) begin
      busy_cyc++;
      if (bus_ready) begin
        if (!bus_we) begin
          chk("R2/R3 read addr", {11'd0, bus_io, bus_addr},
              cur_m[1] ? {11'd0, 1'b1, 4'h0, IOA} : {11'd0, 1'b0, exp_ma(byte_idx)});
        end else begin
          chk("R2/R3/R4/R8 write", {3'd0, bus_io, bus_addr, bus_wdata},
              cur_m[1] ? {3'd0, 1'b0, exp_ma(byte_idx), 8'(byte_idx) ^ 8'h3C}
                       : {3'd0, 1'b1, 4'h0, IOA, exp_ma(byte_idx)[7:0] ^ 8'hA5});
          byte_idx++;
        end
      end
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [19:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [19:0] d);
    @(negedge clk);
    reg_addr = a;
    #2;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    logic [19:0] rv;
    int k;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0; dreq = 1'b0;
    wait_mode = 1'b0; bus_ready = 1'b1; cur_m = 2'b00; cur_base = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rreg(3'(a), rv);
      chk("R1 reset reg", 32'(rv), 32'd0);
    end
    chk("R1 reset done/bus_req", {30'd0, done, bus_req}, 32'd0);

    // table-driven level-sense runs
    for (int i = 0; i < 8; i++) begin
      logic [39:0] v;
      logic [19:0] fin;
      v = VEC[i];
      cur_m = v[37:36]; cur_base = v[35:16]; byte_idx = 0;
      wreg(3'd0, v[35:16]);
      wreg(3'd1, 20'(IOA));
      wreg(3'd2, 20'(v[15:0]));
      wait_mode = v[39];
      dreq = 1'b1;
      busy_cyc = 0;
      wreg(3'd3, {15'd0, 1'b0, 1'b0, v[37:36], 1'b1});
      k = 0;
      while (!done && k < 500) begin @(negedge clk); k++; end
      repeat (4) @(negedge clk);
      dreq = 1'b0; wait_mode = 1'b0;
      chk("R5 bytes moved", 32'(byte_idx), 32'(v[15:0]));
      rreg(3'd3, rv);
      chk("R5 done set, enable clear", 32'(rv[4:0]), {27'd0, 1'b1, 1'b0, v[37:36], 1'b0});
      rreg(3'd2, rv);
      chk("R5 count zero", 32'(rv), 32'd0);
      fin = v[36] ? (v[35:16] - 20'(v[15:0])) : (v[35:16] + 20'(v[15:0]));
      rreg(3'd0, rv);
      chk("R8 final pointer", 32'(rv), 32'(fin));
      if (!v[39]) chk("R6 back-to-back bus cycles", 32'(busy_cyc), 32'(2 * v[15:0]));
      else        chk("R11 stalls lengthen run", 32'(busy_cyc > 2 * v[15:0]), 32'd1);
    end

    // R6 level sample point: request low in read, high in write -> continues
    cur_m = 2'b00; cur_base = 20'h00300; byte_idx = 0;
    wreg(3'd0, 20'h00300); wreg(3'd2, 20'd5); wreg(3'd3, 20'h00001);
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    repeat (10) @(negedge clk);
    chk("R6 continue sampled in write cycle", 32'(byte_idx), 32'd2);
    // request high in read, low in write -> stops after one byte
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    repeat (10) @(negedge clk);
    chk("R6 stop sampled in write cycle", 32'(byte_idx), 32'd3);
    rreg(3'd2, rv);
    chk("R6 count left", 32'(rv), 32'd2);
    wreg(3'd3, 20'h00000);

    // R7 edge sense
    cur_m = 2'b10; cur_base = 20'h00400; byte_idx = 0;
    wreg(3'd0, 20'h00400); wreg(3'd2, 20'd4); wreg(3'd3, 20'h0000D);
    dreq = 1'b1;
    repeat (20) @(negedge clk);
    chk("R7 held request gives one byte", 32'(byte_idx), 32'd1);
    dreq = 1'b0;
    repeat (3) @(negedge clk);
    dreq = 1'b1; @(negedge clk);
    dreq = 1'b0; @(negedge clk);
    dreq = 1'b1; @(negedge clk);
    dreq = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 edge during byte remembered", 32'(byte_idx), 32'd3);

    // R9 writes while armed are ignored
    wreg(3'd0, 20'hABCDE);
    rreg(3'd0, rv);
    chk("R9 pointer write ignored", 32'(rv), 32'h00403);
    wreg(3'd2, 20'd9);
    rreg(3'd2, rv);
    chk("R9 count write ignored", 32'(rv), 32'd1);
    dreq = 1'b1; @(negedge clk); dreq = 1'b0;
    repeat (8) @(negedge clk);
    chk("R5 done after last edge byte", {31'd0, done}, 32'd1);
    rreg(3'd0, rv);
    chk("R5 pointer after edge run", 32'(rv), 32'h00404);

    // R10 stop during a byte
    cur_m = 2'b01; cur_base = 20'h00800; byte_idx = 0;
    wreg(3'd0, 20'h00800); wreg(3'd2, 20'd10); dreq = 1'b1; wreg(3'd3, 20'h00003);
    repeat (5) @(negedge clk);
    #2;
    while (!(bus_req && !bus_we)) begin @(negedge clk); #2; end
    k = byte_idx;
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 20'h00000;
    @(negedge clk); reg_wr = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 in-flight byte completes", 32'(byte_idx), 32'(k + 1));
    rreg(3'd2, rv);
    chk("R10 count after stop", 32'(rv), 32'(10 - k - 1));
    rreg(3'd3, rv);
    chk("R10 disarmed, not done", 32'(rv[4:0]), {27'd0, 5'b00010});
    busy_cyc = 0;
    repeat (10) @(negedge clk);
    chk("R10 no further bus cycles", 32'(busy_cyc), 32'd0);
    dreq = 1'b0;

    finish_run();
  end
endmodule